// File: doc/BRIEF.md
# Approximate LRU Recency Stack with Random Victim Picker

The block tracks which physical frames were touched most recently. Every reference presents a frame number. The block holds up to DEPTH of these numbers in order, newest first and oldest last. A frame that is referenced again moves to the newest position. A new frame that arrives when the list is already full pushes the oldest entry out. A memory manager uses the list to protect recently used frames from eviction.

When the manager needs a frame to reclaim, it raises a victim request. The block then returns one frame that is not currently held in the list. The search begins at a pseudo-random frame, which is taken from an 8-bit maximal-length LFSR that advances every cycle. From there it walks forward through the frame numbers, one per cycle, wrapping at the end, and stops at the first frame that is absent from the list. Each probe is compared against the list as it will stand after any reference made in the same cycle. A reference issued alongside a probe is therefore never missed.

Top module: `frame_recency_top`

## Requirements
- R1: After reset, all list entries are invalid and victimValid is low, so every frame is eligible as a victim.
- R2: A reference to a frame not in the list places that frame in the newest slot, and every valid entry moves one slot toward the oldest end. Valid entries always fill a contiguous run starting at the newest slot.
- R3: A reference to a frame already in the list moves it to the newest slot. Only the entries that were newer than it shift by one, and no entry is lost: the number of valid entries is unchanged.
- R4: A reference to a new frame while all DEPTH slots are valid discards the oldest entry, and the list stays full.
- R5: When victimValid is high, victimFrame is a frame absent from the list. This includes the effect of a reference made in the same cycle as the deciding probe.
- R6: victimReq is sampled only while no search is running. With no reference during the search, victimValid is a single-cycle pulse arriving 1 to DEPTH+1 clock edges after the edge that sampled the request.
- R7: The search start comes from an 8-bit maximal-length LFSR that never holds zero. Repeated requests against an unchanged list may return different frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| refValid | input | 1 | A frame reference is presented this cycle |
| refFrame | input | FW = clog2(NUM_FRAMES) | Referenced frame number |
| victimReq | input | 1 | Request a victim frame (sampled while idle) |
| victimFrame | output | FW | Chosen victim frame, meaningful while victimValid is high |
| victimValid | output | 1 | One-cycle pulse marking a returned victim |

## Verification
A reference alters the list at the next clock edge. A victim appears between one and DEPTH+1 edges after its request is sampled. The bench therefore drives its inputs on the falling edge. It updates its own recency model at each rising edge, using the references applied there, and inspects victimValid on the following falling edge. At that point the victim must be absent from the model as it stands after that edge. A second instance with 16 frames and 15 slots leaves exactly one frame absent from a full list, so the victim is fully determined. This lets the bench check the exact order of move-to-top and drop-oldest.

// File: rtl/frame_recency_pkg.sv
package frame_recency_pkg;
  localparam int LFSR_W = 8;

  typedef enum logic {
    S_IDLE,
    S_SEARCH
  } search_state_e;

  // strobes from control to the list datapath
  typedef struct packed {
    logic push;   // apply a reference this cycle
    logic probe;  // a search probe is active this cycle
  } list_ctrl_s;
endpackage

// File: rtl/recency_list_dp.sv
module recency_list_dp
  import frame_recency_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  list_ctrl_s                 ctrl,
  input  logic [FW-1:0]              refFrame,
  input  logic [FW-1:0]              probeFrame,
  output logic                       probeAbsent,
  output logic [DEPTH-1:0][FW-1:0]   entryFrame,
  output logic [DEPTH-1:0]           entryValid
);
  logic [DEPTH-1:0][FW-1:0] curFrame, nxtFrame;
  logic [DEPTH-1:0]         curValid, nxtValid;
  logic [DEPTH-1:0]         match, matchAbove, probeHits;
  logic                     refHit, listFull;

  // associative compare and prefix of matches above each slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match[i] = curValid[i] && (curFrame[i] == refFrame);
    if (i == 0) begin : g_first
      assign matchAbove[i] = 1'b0;
    end else begin : g_rest
      assign matchAbove[i] = matchAbove[i-1] | match[i-1];
    end
  end

  assign refHit   = |match;
  assign listFull = &curValid;

  // next-state list: slot 0 takes the reference, others shift unless a
  // match sits above them (those below the hit keep their place)
  for (genvar i = 0; i < DEPTH; i++) begin : g_next
    if (i == 0) begin : g_top
      always_comb begin
        nxtFrame[i] = ctrl.push ? refFrame : curFrame[i];
        nxtValid[i] = ctrl.push ? 1'b1     : curValid[i];
      end
    end else begin : g_below
      always_comb begin
        if (ctrl.push && !matchAbove[i]) begin
          nxtFrame[i] = curFrame[i-1];
          nxtValid[i] = curValid[i-1];
        end else begin
          nxtFrame[i] = curFrame[i];
          nxtValid[i] = curValid[i];
        end
      end
    end
  end

  // probe against the post-reference list
  for (genvar i = 0; i < DEPTH; i++) begin : g_probe
    assign probeHits[i] = nxtValid[i] && (nxtFrame[i] == probeFrame);
  end
  assign probeAbsent = ctrl.probe && !(|probeHits);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curValid <= '0;
      curFrame <= '0;
    end else begin
      curValid <= nxtValid;
      curFrame <= nxtFrame;
    end
  end

  assign entryFrame = curFrame;
  assign entryValid = curValid;

  AST_TOP_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.push |=> (curValid[0] && curFrame[0] == $past(refFrame))); // R2
  AST_VALID_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    ((curValid & (curValid + DEPTH'(1))) == '0)); // R2
  AST_HOLD_WITHOUT_REF: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.push |=> ($stable(curValid) && $stable(curFrame))); // R2
  AST_HIT_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.push && refHit) |=> ($countones(curValid) == $countones($past(curValid)))); // R3
  AST_FULL_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.push && listFull) |=> (&curValid)); // R4
endmodule

// File: rtl/victim_search_ctrl.sv
module victim_search_ctrl
  import frame_recency_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int FW    = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       refValid,
  input  logic                       victimReq,
  input  logic                       probeAbsent,
  input  logic [DEPTH-1:0][FW-1:0]   entryFrame,
  input  logic [DEPTH-1:0]           entryValid,
  output list_ctrl_s                 ctrl,
  output logic [FW-1:0]              probeFrame,
  output logic [FW-1:0]              victimFrame,
  output logic                       victimValid
);
  search_state_e       state;
  logic [LFSR_W-1:0]   lfsr;
  logic                lfsrFb;
  logic [31:0]         lfsrWide;
  logic [FW-1:0]       startIdx, cand;
  logic                victimHeld;

  // x^8 + x^6 + x^5 + x^4 + 1, maximal length
  assign lfsrFb   = lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3];
  assign lfsrWide = 32'(lfsr);
  assign startIdx = lfsrWide[FW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= LFSR_W'(1);
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsrFb};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cand        <= '0;
      victimFrame <= '0;
      victimValid <= 1'b0;
    end else begin
      victimValid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (victimReq) begin
            cand  <= startIdx;
            state <= S_SEARCH;
          end
        end
        S_SEARCH: begin
          if (probeAbsent) begin
            victimFrame <= cand;
            victimValid <= 1'b1;
            state       <= S_IDLE;
          end else begin
            cand <= cand + FW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.push  = refValid;
    ctrl.probe = (state == S_SEARCH);
  end
  assign probeFrame = cand;

  always_comb begin
    victimHeld = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (entryValid[i] && entryFrame[i] == victimFrame) victimHeld = 1'b1;
    end
  end

  AST_VICTIM_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> !victimHeld); // R5
  AST_VICTIM_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |=> !victimValid); // R6
  AST_PULSE_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    victimValid |-> (state == S_IDLE)); // R6
  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0); // R7
endmodule

// File: rtl/frame_recency_top.sv
module frame_recency_top
  import frame_recency_pkg::*;
#(
  parameter int NUM_FRAMES = 64,
  parameter int DEPTH      = 16,
  localparam int FW        = $clog2(NUM_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          refValid,
  input  logic [FW-1:0] refFrame,
  input  logic          victimReq,
  output logic [FW-1:0] victimFrame,
  output logic          victimValid
);
  list_ctrl_s               ctrl;
  logic [FW-1:0]            probeFrame;
  logic                     probeAbsent;
  logic [DEPTH-1:0][FW-1:0] entryFrame;
  logic [DEPTH-1:0]         entryValid;

  initial begin
    if ((1 << FW) != NUM_FRAMES) $error("NUM_FRAMES must be a power of two");
    if (DEPTH >= NUM_FRAMES) $error("DEPTH must be below NUM_FRAMES");
  end

  victim_search_ctrl #(.DEPTH(DEPTH), .FW(FW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .refValid(refValid), .victimReq(victimReq),
    .probeAbsent(probeAbsent), .entryFrame(entryFrame), .entryValid(entryValid),
    .ctrl(ctrl), .probeFrame(probeFrame), .victimFrame(victimFrame),
    .victimValid(victimValid)
  );

  recency_list_dp #(.DEPTH(DEPTH), .FW(FW)) u_list (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .refFrame(refFrame),
    .probeFrame(probeFrame), .probeAbsent(probeAbsent),
    .entryFrame(entryFrame), .entryValid(entryValid)
  );
endmodule

// File: tb/frame_recency_top_bench.sv
module frame_recency_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int A_FRAMES = 64, A_DEPTH = 16;
  localparam int B_FRAMES = 16, B_DEPTH = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic refVA = 0, reqA = 0, refVB = 0, reqB = 0;
  logic [5:0] refFA = '0;
  logic [3:0] refFB = '0;
  logic [5:0] vfA;
  logic [3:0] vfB;
  logic vvA, vvB;

  frame_recency_top #(.NUM_FRAMES(A_FRAMES), .DEPTH(A_DEPTH)) u_frame_recency_top (
    .clk(clk), .rst_n(rst_n), .refValid(refVA), .refFrame(refFA),
    .victimReq(reqA), .victimFrame(vfA), .victimValid(vvA));

  frame_recency_top #(.NUM_FRAMES(B_FRAMES), .DEPTH(B_DEPTH)) u_frame_recency_top_small (
    .clk(clk), .rst_n(rst_n), .refValid(refVB), .refFrame(refFB),
    .victimReq(reqB), .victimFrame(vfB), .victimValid(vvB));

  int modelA[$];
  int modelB[$];
  int checks = 0, fails = 0;
  bit busyA = 0, busyB = 0, quietA = 0, quietB = 0, gotA = 0, gotB = 0;
  bit prevVvA = 0, prevVvB = 0;
  int latA = 0, latB = 0, lastA = 0, lastB = 0;

  function automatic bit holds(int m[$], int f);
    foreach (m[i]) if (m[i] == f) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int missingSmall(int m[$]);
    for (int f = 0; f < B_FRAMES; f++) if (!holds(m, f)) return f;
    return -1;
  endfunction

  function automatic void updA(int f);
    foreach (modelA[i]) if (modelA[i] == f) begin modelA.delete(i); break; end
    modelA.push_front(f);
    if (modelA.size() > A_DEPTH) void'(modelA.pop_back());
  endfunction

  function automatic void updB(int f);
    foreach (modelB[i]) if (modelB[i] == f) begin modelB.delete(i); break; end
    modelB.push_front(f);
    if (modelB.size() > B_DEPTH) void'(modelB.pop_back());
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock: edge bookkeeping, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    if (busyA) begin latA++; if (refVA) quietA = 0; end
    if (busyB) begin latB++; if (refVB) quietB = 0; end
    if (refVA) updA(int'(refFA));
    if (refVB) updB(int'(refFB));
    if (reqA && !busyA) begin busyA = 1; latA = 0; quietA = 1; end
    if (reqB && !busyB) begin busyB = 1; latB = 0; quietB = 1; end
    @(negedge clk);
    refVA = 0; reqA = 0; refVB = 0; reqB = 0;
    if (vvA) begin
      check(busyA && !prevVvA, "R6 pulse A", int'(vvA), 0);
      check(!holds(modelA, int'(vfA)), "R5 victim A absent", int'(vfA), -1);
      if (quietA) check(latA >= 1 && latA <= A_DEPTH + 1, "R6 latency A", latA, A_DEPTH + 1);
      busyA = 0; gotA = 1; lastA = int'(vfA);
    end
    if (vvB) begin
      check(busyB && !prevVvB, "R6 pulse B", int'(vvB), 0);
      check(!holds(modelB, int'(vfB)), "R5 victim B absent", int'(vfB), -1);
      if (modelB.size() == B_DEPTH)
        check(int'(vfB) == missingSmall(modelB), "R5 exact victim B", int'(vfB), missingSmall(modelB));
      if (quietB) check(latB >= 1 && latB <= B_DEPTH + 1, "R6 latency B", latB, B_DEPTH + 1);
      busyB = 0; gotB = 1; lastB = int'(vfB);
    end
    prevVvA = vvA; prevVvB = vvB;
  endtask

  task automatic victimB(int exp, string req);
    gotB = 0; reqB = 1; step();
    for (int k = 0; k < 100 && !gotB; k++) step();
    check(gotB && lastB == exp, req, lastB, exp);
  endtask

  task automatic refB(int f);
    refVB = 1; refFB = 4'(f); step();
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int seen[$];
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(vvA == 0, "R1 victimValid A after reset", int'(vvA), 0);
    check(vvB == 0, "R1 victimValid B after reset", int'(vvB), 0);

    // R1 R2: fill small list with 0..14, only 15 remains
    for (int f = 0; f < B_DEPTH; f++) refB(f);
    victimB(15, "R2 victim after fill");
    // R4: new frame on full list drops oldest (0)
    refB(15);
    victimB(0, "R4 oldest dropped");
    // R3: hit moves 1 to top, nothing dropped
    refB(1);
    victimB(0, "R3 hit keeps entries");
    // R3 R4: after move-to-top, oldest is now 2
    refB(0);
    victimB(2, "R3 move-to-top order");

    // R7: large list with unchanged contents, repeated requests
    for (int k = 0; k < A_DEPTH; k++) begin refVA = 1; refFA = 6'(4 * k); step(); end
    for (int n = 0; n < 8; n++) begin
      gotA = 0; reqA = 1; step();
      for (int k = 0; k < 100 && !gotA; k++) step();
      check(gotA, "R6 victim A returned", int'(gotA), 1);
      if (!holds(seen, lastA)) seen.push_back(lastA);
      for (int k = 0; k < ($urandom % 7); k++) step();
    end
    check(seen.size() >= 2, "R7 varied victims", seen.size(), 2);

    // R5: random references, including ones in the same cycle as probes
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 2 == 0) begin refVA = 1; refFA = 6'($urandom % A_FRAMES); end
      if ($urandom % 3 != 0) begin refVB = 1; refFB = 4'($urandom % B_FRAMES); end
      if (!busyA && ($urandom % 4 == 0)) reqA = 1;
      if (!busyB && ($urandom % 4 == 0)) reqB = 1;
      step();
    end
    for (int k = 0; k < 200 && (busyA || busyB); k++) step();
    check(!busyA && !busyB, "R5 searches completed", int'(busyA) + int'(busyB), 0);
    finishRun();
  end
endmodule